// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory with Access Timing

This block is a cycle-based model of a byte-wide, one-time-programmable memory and its control logic. Three active-low strobes select the operation: chip select, output enable and program strobe. Two digital flags replace the analog levels. One flag says the programming supply is raised. The other says the high identification voltage is present on address line 9. The memory can be read and programmed. It can also return a fixed pair of identifier bytes. Output access and float delays are modelled as counts of clock cycles.

A fresh or reset array holds all ones. Programming can only clear bits, so a program cycle stores the old word ANDed with the input byte. The data bus comes with two flags. A drive flag controls an external tri-state buffer. A valid flag is high only once both the address access time and the output-enable access time have run out. Chip select high forces standby and releases the bus, whatever output enable does. The array depth is a parameter. Each address is folded onto the array by its low bits, so a small array can stand in for the full one.

Top module: `otp_byte_mem`

## Requirements
- R1: After reset every word reads FFh, standby is 1, and dout_oe and dout_valid are 0.
- R2: When chip select and output enable are both low and the ID flag is low, dout carries the word at index addr mod DEPTH once dout_valid is 1.
- R3: Chip select high at a clock edge sets standby after that edge and clears dout_valid, whether output enable is high or low.
- R4: Chip select low with output enable high (not programming) clears dout_valid, and the bus floats after the float delay.
- R5: A clock edge that samples the supply flag high, chip select low, program strobe low and output enable high changes the addressed word to old AND din.
- R6: A program strobe with chip select high, or with the supply flag low, leaves the array unchanged.
- R7: Reading with the supply flag high and program strobe high (verify) returns the stored word, including a word programmed just before.
- R8: With the ID flag high and chip select and output enable low, dout is 01h when addr bit 0 is 0 and 0Eh when it is 1. All other address bits are ignored. Both codes have an odd number of ones, with bit 7 as the parity bit.
- R9: Counting the first edge that samples a new address, chip select falling or an ID flag change as edge 1, dout_valid is 0 after edges 1 to ADDR_LAT-1 and is 1 after edge ADDR_LAT (default 4), provided output enable has been low long enough.
- R10: With the address settled, dout_valid becomes 1 after the OE_LAT-th edge (default 2) that samples output enable low, and not before.
- R11: dout_oe is 1 after the first edge that samples chip select and output enable both low. After the first edge that samples either one high, it stays 1 for FLT_LAT-1 more edges and is 0 after edge FLT_LAT (default 2).
- R12: Whenever dout_valid is 0, dout is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, erases the array |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| pgm_n | input | 1 | Active-low program strobe |
| vpp_hi | input | 1 | Programming supply raised |
| id_hv | input | 1 | Identification voltage present on address line 9 |
| addr | input | ADDR_W (17) | Word address |
| din | input | DATA_W (8) | Byte to program |
| dout | output | DATA_W (8) | Read data, zero while not valid |
| dout_oe | output | 1 | Enable for the external tri-state driver |
| dout_valid | output | 1 | Read data valid, access time elapsed |
| standby | output | 1 | Chip is deselected |

## Verification
A program cycle can land while the float tail of the read just before it is still driving the bus. The bench provokes this by raising output enable and starting the program strobe at the same edge that ends a valid read. It then expects dout_oe still high, dout_valid low and dout zero in that cycle. A verify read that follows must show the ANDed byte after exactly OE_LAT edges, because the address access time has already run out. The random phase mixes aliased addresses, inhibited program attempts and identifier reads with junk upper address bits, and compares each result with a bench model of the array.

// File: rtl/otpm_pkg.sv
package otpm_pkg;

   typedef enum logic [2:0] {
      OM_STANDBY = 3'd0,
      OM_DISABLE = 3'd1,
      OM_PROGRAM = 3'd2,
      OM_READ    = 3'd3,
      OM_IDENT   = 3'd4
   } otpm_mode_e;

endpackage

// File: rtl/otpm_mode_dec.sv
module otpm_mode_dec
   import otpm_pkg::*;
(
   input  logic       ce_n,
   input  logic       oe_n,
   input  logic       pgm_n,
   input  logic       vpp_hi,
   input  logic       id_hv,
   output otpm_mode_e mode
);

   // Chip select dominates; program needs outputs released; ID wins over read.
   always_comb begin
      if (ce_n)
         mode = OM_STANDBY;
      else if (!oe_n)
         mode = id_hv ? OM_IDENT : OM_READ;
      else if (vpp_hi && !pgm_n)
         mode = OM_PROGRAM;
      else
         mode = OM_DISABLE;
   end

endmodule

// File: rtl/otpm_array.sv
module otpm_array #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 1024,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] cells [DEPTH];

   // Reset stands in for erasure; a write can only clear bits.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
      end else if (wr_en) begin
         cells[idx] <= cells[idx] & wdata;
      end
   end

   assign rdata = cells[idx];

endmodule

// File: rtl/otpm_timing.sv
module otpm_timing #(
   parameter int ADDR_W   = 17,
   parameter int ADDR_LAT = 4,
   parameter int OE_LAT   = 2,
   parameter int FLT_LAT  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              id_hv,
   input  logic [ADDR_W-1:0] addr,
   output logic              acc_ok,
   output logic              drive
);

   localparam int AW = $clog2(ADDR_LAT + 1);
   localparam int OW = $clog2(OE_LAT + 1);
   localparam logic [AW-1:0] A_MAX = AW'(ADDR_LAT);
   localparam logic [OW-1:0] O_MAX = OW'(OE_LAT);

   logic [AW-1:0]     a_cnt;
   logic [OW-1:0]     o_cnt;
   logic [ADDR_W-1:0] addr_q;
   logic              id_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_cnt  <= '0;
         o_cnt  <= '0;
         addr_q <= '0;
         id_q   <= 1'b0;
      end else begin
         addr_q <= addr;
         id_q   <= id_hv;
         if (ce_n)
            a_cnt <= '0;
         else if (addr != addr_q || id_hv != id_q)
            a_cnt <= AW'(1);
         else if (a_cnt != A_MAX)
            a_cnt <= a_cnt + AW'(1);
         if (ce_n || oe_n)
            o_cnt <= '0;
         else if (o_cnt != O_MAX)
            o_cnt <= o_cnt + OW'(1);
      end
   end

   assign acc_ok = (a_cnt == A_MAX) && (o_cnt == O_MAX);

   generate
      if (FLT_LAT == 1) begin : g_flt_direct
         logic drv_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) drv_q <= 1'b0;
            else        drv_q <= !ce_n && !oe_n;
         end
         assign drive = drv_q;
      end else begin : g_flt_count
         localparam int FW = $clog2(FLT_LAT + 1);
         localparam logic [FW-1:0] F_MAX = FW'(FLT_LAT);
         logic [FW-1:0] f_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               f_cnt <= '0;
            else if (!ce_n && !oe_n)
               f_cnt <= F_MAX;
            else if (f_cnt != '0)
               f_cnt <= f_cnt - FW'(1);
         end
         assign drive = (f_cnt != '0);
      end
   endgenerate

endmodule

// File: rtl/otp_byte_mem.sv
module otp_byte_mem
   import otpm_pkg::*;
#(
   parameter int                ADDR_W   = 17,
   parameter int                DATA_W   = 8,
   parameter int                DEPTH    = 1024,
   parameter int                ADDR_LAT = 4,
   parameter int                OE_LAT   = 2,
   parameter int                FLT_LAT  = 2,
   parameter logic [DATA_W-1:0] MFR_CODE = 8'h01,
   parameter logic [DATA_W-1:0] DEV_CODE = 8'h0E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              pgm_n,
   input  logic              vpp_hi,
   input  logic              id_hv,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_oe,
   output logic              dout_valid,
   output logic              standby
);

   localparam int IDX_W = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0 || IDX_W > ADDR_W) begin : g_bad_depth
         $error("DEPTH must be a power of two between 2 and 2**ADDR_W");
      end
      if (OE_LAT < 1 || ADDR_LAT <= OE_LAT) begin : g_bad_lat
         $error("need ADDR_LAT > OE_LAT >= 1");
      end
      if (FLT_LAT < 1) begin : g_bad_flt
         $error("FLT_LAT must be at least 1");
      end
      if (^MFR_CODE != 1'b1 || ^DEV_CODE != 1'b1) begin : g_bad_par
         $error("identifier codes must have odd parity");
      end
   endgenerate

   otpm_mode_e        mode;
   logic [DATA_W-1:0] rdata;
   logic [DATA_W-1:0] data_q;
   logic              standby_q;
   logic              acc_ok;
   logic              drive;

   otpm_mode_dec u_dec (
      .ce_n   (ce_n),
      .oe_n   (oe_n),
      .pgm_n  (pgm_n),
      .vpp_hi (vpp_hi),
      .id_hv  (id_hv),
      .mode   (mode)
   );

   otpm_array #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_arr (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (mode == OM_PROGRAM),
      .idx   (addr[IDX_W-1:0]),
      .wdata (din),
      .rdata (rdata)
   );

   otpm_timing #(
      .ADDR_W   (ADDR_W),
      .ADDR_LAT (ADDR_LAT),
      .OE_LAT   (OE_LAT),
      .FLT_LAT  (FLT_LAT)
   ) u_tim (
      .clk    (clk),
      .rst_n  (rst_n),
      .ce_n   (ce_n),
      .oe_n   (oe_n),
      .id_hv  (id_hv),
      .addr   (addr),
      .acc_ok (acc_ok),
      .drive  (drive)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q    <= '0;
         standby_q <= 1'b1;
      end else begin
         data_q    <= (mode == OM_IDENT) ? (addr[0] ? DEV_CODE : MFR_CODE) : rdata;
         standby_q <= (mode == OM_STANDBY);
      end
   end

   assign dout_valid = acc_ok;
   assign dout       = acc_ok ? data_q : '0;
   assign dout_oe    = drive;
   assign standby    = standby_q;

endmodule

// File: rtl/otpm_chk.sv
module otpm_chk #(
   parameter int                ADDR_W   = 17,
   parameter int                DATA_W   = 8,
   parameter logic [DATA_W-1:0] MFR_CODE = 8'h01,
   parameter logic [DATA_W-1:0] DEV_CODE = 8'h0E
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              oe_n,
   input logic              id_hv,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] dout,
   input logic              dout_oe,
   input logic              dout_valid,
   input logic              standby
);

   AST_STANDBY_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |=> (standby && !dout_valid)); // R3

   AST_DISABLE_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && oe_n) |=> !dout_valid); // R4

   AST_ID_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_valid && $past(id_hv)) |-> (dout == ($past(addr[0]) ? DEV_CODE : MFR_CODE))); // R8

   AST_ADDR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && addr != $past(addr)) |=> !dout_valid); // R9

   AST_DRIVE_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !oe_n) |=> dout_oe); // R11

   AST_VALID_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      dout_valid |-> dout_oe); // R11

   AST_ZERO_WHEN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_valid |-> (dout == '0)); // R12

endmodule

bind otp_byte_mem otpm_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .MFR_CODE (MFR_CODE),
   .DEV_CODE (DEV_CODE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ce_n       (ce_n),
   .oe_n       (oe_n),
   .id_hv      (id_hv),
   .addr       (addr),
   .dout       (dout),
   .dout_oe    (dout_oe),
   .dout_valid (dout_valid),
   .standby    (standby)
);

// File: tb/otp_byte_mem_tb.sv
module otp_byte_mem_tb;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 17;
   localparam int DATA_W     = 8;
   localparam int DEPTH      = 64;
   localparam int ADDR_LAT   = 4;
   localparam int OE_LAT     = 2;
   localparam int FLT_LAT    = 2;
   localparam int WD_CYCLES  = 150000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1;
   logic              vpp_hi = 1'b0, id_hv = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [DATA_W-1:0] din = '0;
   logic [DATA_W-1:0] dout;
   logic              dout_oe, dout_valid, standby;

   int checks = 0;
   int fails  = 0;
   logic [DATA_W-1:0] model [DEPTH];

   always #(CLK_PERIOD/2) clk = ~clk;

   otp_byte_mem #(
      .ADDR_W (ADDR_W), .DATA_W (DATA_W), .DEPTH (DEPTH),
      .ADDR_LAT (ADDR_LAT), .OE_LAT (OE_LAT), .FLT_LAT (FLT_LAT)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .ce_n (ce_n), .oe_n (oe_n), .pgm_n (pgm_n),
      .vpp_hi (vpp_hi), .id_hv (id_hv), .addr (addr), .din (din),
      .dout (dout), .dout_oe (dout_oe), .dout_valid (dout_valid), .standby (standby)
   );

   function automatic logic [DATA_W-1:0] id_exp(input logic [ADDR_W-1:0] a);
      return a[0] ? 8'h0E : 8'h01;
   endfunction

   function automatic int word_of(input logic [ADDR_W-1:0] a);
      return int'(a) % DEPTH;
   endfunction

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle();
      ce_n = 1'b1; oe_n = 1'b1; pgm_n = 1'b1; vpp_hi = 1'b0; id_hv = 1'b0;
   endtask

   // full read from a deselected start; checks access timing and data
   task automatic do_read(input logic [ADDR_W-1:0] a, input logic id, input logic [DATA_W-1:0] exp);
      idle();
      repeat (FLT_LAT) tick();
      addr = a; id_hv = id; ce_n = 1'b0; oe_n = 1'b0;
      repeat (ADDR_LAT-1) tick();
      chk("R9 valid before address access", dout_valid, 0);
      chk("R12 dout zero while invalid", dout, 0);
      chk("R11 drive on", dout_oe, 1);
      tick();
      chk("R9 valid at address access", dout_valid, 1);
      chk(id ? "R8 identifier byte" : "R2 read data", dout, exp);
      idle();
   endtask

   // blk: 0 normal program, 1 chip select high, 2 supply flag low
   task automatic do_prog(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input int blk);
      addr = a; din = d; pgm_n = 1'b0; oe_n = 1'b1; id_hv = 1'b0;
      ce_n = (blk == 1); vpp_hi = (blk != 2);
      tick();
      if (blk == 0) model[word_of(a)] = model[word_of(a)] & d;
      idle();
      tick();
   endtask

   initial begin : watchdog
      repeat (WD_CYCLES) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      logic [ADDR_W-1:0] a;
      logic [DATA_W-1:0] d;
      void'($urandom(32'd20240611));
      for (int i = 0; i < DEPTH; i++) model[i] = '1;
      repeat (3) tick();
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 standby after reset", standby, 1);
      chk("R1 drive off after reset", dout_oe, 0);
      chk("R1 invalid after reset", dout_valid, 0);
      tick();

      // R1 / R2 erased word reads all ones
      do_read(17'd5, 1'b0, 8'hFF);

      // R10 output-enable access with settled address
      addr = 17'd9; ce_n = 1'b0; oe_n = 1'b1;
      repeat (ADDR_LAT + 1) tick();
      chk("R4 disabled not valid", dout_valid, 0);
      chk("R4 disabled floats", dout_oe, 0);
      chk("R3 not standby when selected", standby, 0);
      oe_n = 1'b0;
      repeat (OE_LAT - 1) tick();
      chk("R10 valid before oe access", dout_valid, 0);
      tick();
      chk("R10 valid at oe access", dout_valid, 1);
      chk("R10 data", dout, 8'hFF);

      // R11 float after output enable rises
      oe_n = 1'b1;
      repeat (FLT_LAT - 1) tick();
      chk("R11 still driving in float tail", dout_oe, 1);
      chk("R4 invalid in float tail", dout_valid, 0);
      tick();
      chk("R11 floated", dout_oe, 0);

      // R3 standby with output enable low
      ce_n = 1'b0; oe_n = 1'b0;
      repeat (ADDR_LAT) tick();
      chk("R2 valid before standby", dout_valid, 1);
      ce_n = 1'b1;
      tick();
      chk("R3 standby set", standby, 1);
      chk("R3 invalid in standby", dout_valid, 0);
      repeat (FLT_LAT - 1) tick();
      chk("R3 floats in standby with oe low", dout_oe, 0);
      idle(); tick();

      // program during float tail of a read, then verify
      addr = 17'd12; ce_n = 1'b0; oe_n = 1'b0;
      repeat (ADDR_LAT) tick();
      chk("R2 read before program", dout, 8'hFF);
      oe_n = 1'b1; vpp_hi = 1'b1; pgm_n = 1'b0; din = 8'hA5;
      tick();
      model[12] = model[12] & 8'hA5;
      chk("R11 tail drives during program", dout_oe, 1);
      chk("R12 zero during program tail", dout, 0);
      pgm_n = 1'b1; oe_n = 1'b0;
      repeat (OE_LAT - 1) tick();
      chk("R10 verify not yet valid", dout_valid, 0);
      tick();
      chk("R7 verify valid", dout_valid, 1);
      chk("R7 verify data", dout, 8'hA5);
      idle(); tick();

      // R5 second program ANDs
      do_prog(17'd12, 8'h3C, 0);
      do_read(17'd12, 1'b0, 8'h24);
      // R5 aliasing: address folds onto DEPTH words
      do_prog(17'd12 + 17'(DEPTH), 8'hF0, 0);
      do_read(17'd12, 1'b0, 8'h20);

      // R6 inhibit
      do_prog(17'd30, 8'h00, 1);
      do_read(17'd30, 1'b0, 8'hFF);
      do_prog(17'd30, 8'h00, 2);
      do_read(17'd30, 1'b0, 8'hFF);

      // R8 identifier codes, other bits ignored
      do_read(17'h00000, 1'b1, 8'h01);
      do_read(17'h00001, 1'b1, 8'h0E);
      do_read(17'h1FFFE, 1'b1, 8'h01);
      do_read(17'h0ABCD, 1'b1, 8'h0E);
      chk("R8 manufacturer code odd parity", ^8'h01, 1);
      chk("R8 device code odd parity", ^8'h0E, 1);

      // random mix against the bench model
      for (int n = 0; n < 300; n++) begin
         a = ADDR_W'($urandom);
         d = DATA_W'($urandom);
         case ($urandom % 5)
            0, 1: do_prog(a, d, 0);
            2:    do_prog(a, d, 1 + int'($urandom % 2)); // R6
            3:    do_read(a, 1'b0, model[word_of(a)]);   // R2
            default: do_read(a, 1'b1, id_exp(a));        // R8
         endcase
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule